// File: doc/BRIEF.md
# PHY Control Register Bank with Bit-Masked Writes

This block holds the static control settings of a storage-interface PHY and exposes them to software through a small word-addressed register port. Each control register keeps only a 16-bit payload. Every write carries its own per-bit enable in the upper half of the data word. A payload bit changes only where the enable bit sixteen places above it is set. Software can therefore flip one field, such as the DLL enable, without first reading the register back.

The stored payloads drive named control fields straight out to the PHY power-up sequencer: power enable, DLL enable, drive-strength code, DLL frequency band, and the output tap delay enable and select. A separate read-only status word reports two live PHY flags: calibration finished and DLL locked.

Reads are registered. The value selected by the address is captured on the clock edge where the read strobe is high. It appears on the read data port one cycle later and is held until the next read.

Top module: `phyctl_regbank`

## Requirements
- R1: After reset every control payload bit is 0: power off, DLL off, drive code 0, frequency code 0 (top band), tap delay disabled with select 0. The read data port is 0.
- R2: On a write to a control word, payload bit x takes wdata[x] only when wdata[x+16] is 1. Otherwise bit x keeps its previous value.
- R3: A read of a control word returns the payload in bits 15:0 and zeros in bits 31:16. The value appears on rdata in the cycle after the read strobe, and rdata holds its value while no read is issued.
- R4: Control word 6 (byte offset 0x18) drives power enable from bit 0, DLL enable from bit 1, and the 3-bit drive code from bits 6:4.
- R5: Control word 0 (byte offset 0x00) drives the 2-bit DLL frequency code from bits 13:12, the tap delay enable from bit 11, and the 4-bit tap delay select from bits 10:7.
- R6: A read of byte offset 0x20 returns calibration-done in bit 6 and DLL-ready in bit 5, sampled on the strobe edge. All other bits are 0.
- R7: Writes to offset 0x20, to offsets with no control word behind them, or to byte addresses with bits 1:0 not zero change no control bit. Reads of such addresses return 0.
- R8: Control words 1 through 5 (offsets 0x04 to 0x14) store all 16 payload bits and read them back unchanged.
- R9: When a write and a read hit the same control word in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Enable mask in [31:16], payload in [15:0] |
| rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | PHY calibration finished flag |
| dll_ready_i | input | 1 | PHY DLL locked flag |
| pwr_en_o | output | 1 | PHY power enable |
| dll_en_o | output | 1 | DLL enable |
| drv_code_o | output | 3 | Output drive-strength code |
| dll_freq_o | output | 2 | DLL frequency band code |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |

## Verification
The hardest case to reach from the ports is a write that must leave every bit alone: a zero enable mask, a status-offset write, a misaligned address, or an offset past the last control word. Each of these looks identical at the outputs to a correct write that happens to change nothing. The bench first loads distinct non-zero patterns into every word, so each one is known. It then issues the ignored writes with all-ones data, and reads every word and every field output back against its own model. The same-cycle write/read collision is driven by raising both strobes in one cycle and comparing rdata against the old model value before updating the model.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    // Control word holding the power and DLL switches
    localparam int PWR_WORD   = 6;
    localparam int PWR_BIT    = 0;
    localparam int DLLEN_BIT  = 1;
    localparam int DRV_LSB    = 4;
    localparam int DRV_W      = 3;

    // Control word holding the DLL band and tap delay
    localparam int DLY_WORD   = 0;
    localparam int FREQ_LSB   = 12;
    localparam int FREQ_W     = 2;
    localparam int OTEN_BIT   = 11;
    localparam int OTSEL_LSB  = 7;
    localparam int OTSEL_W    = 4;

    // Status word bit positions
    localparam int CAL_BIT    = 6;
    localparam int RDY_BIT    = 5;

    typedef enum logic [1:0] {
        ACC_CTRL     = 2'd0,
        ACC_STATUS   = 2'd1,
        ACC_UNMAPPED = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/phyctl_addr_dec.sv
module phyctl_addr_dec
    import phyctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_CTRL    = 7,
    parameter int STATUS_WORD = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output acc_kind_e           kind,
    output logic [NUM_CTRL-1:0] sel
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] STATUS_IDX = WIDX_W'(STATUS_WORD);

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    always_comb begin
        widx    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        sel     = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (aligned && (widx == WIDX_W'(i))) begin
                sel[i] = 1'b1;
            end
        end
        if (!aligned) begin
            kind = ACC_UNMAPPED;
        end else if (widx == STATUS_IDX) begin
            kind = ACC_STATUS;
        end else if (|sel) begin
            kind = ACC_CTRL;
        end else begin
            kind = ACC_UNMAPPED;
        end
    end

endmodule

// File: rtl/phyctl_mask_reg.sv
module phyctl_mask_reg #(
    parameter int HALF = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [HALF-1:0] din,
    input  logic [HALF-1:0] mask,
    output logic [HALF-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~mask) | (din & mask);
        end
    end

endmodule

// File: rtl/phyctl_rd_path.sv
module phyctl_rd_path
    import phyctl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_CTRL = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  acc_kind_e                 kind,
    input  logic [NUM_CTRL-1:0]       sel,
    input  logic [NUM_CTRL*(DATA_W/2)-1:0] ctrl_flat,
    input  logic                      cal_done,
    input  logic                      dll_ready,
    output logic [DATA_W-1:0]         rdata
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0]   ctrl_rd;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (sel[i]) begin
                ctrl_rd = ctrl_rd | ctrl_flat[i*HALF +: HALF];
            end
        end
        rd_next = '0;
        unique case (kind)
            ACC_CTRL: begin
                rd_next = {{HALF{1'b0}}, ctrl_rd};
            end
            ACC_STATUS: begin
                rd_next[CAL_BIT] = cal_done;
                rd_next[RDY_BIT] = dll_ready;
            end
            default: begin
                rd_next = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank
    import phyctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_CTRL    = 7,
    parameter int STATUS_WORD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cal_done_i,
    input  logic              dll_ready_i,
    output logic              pwr_en_o,
    output logic              dll_en_o,
    output logic [2:0]        drv_code_o,
    output logic [1:0]        dll_freq_o,
    output logic              otap_en_o,
    output logic [3:0]        otap_sel_o
);
    localparam int HALF = DATA_W / 2;

    acc_kind_e                  kind;
    logic [NUM_CTRL-1:0]        sel;
    logic [HALF-1:0]            ctrl_q [NUM_CTRL];
    logic [NUM_CTRL*HALF-1:0]   ctrl_flat;

    phyctl_addr_dec #(
        .ADDR_W      (ADDR_W),
        .NUM_CTRL    (NUM_CTRL),
        .STATUS_WORD (STATUS_WORD)
    ) u_dec (
        .addr (addr),
        .kind (kind),
        .sel  (sel)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        phyctl_mask_reg #(
            .HALF (HALF)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en & sel[g]),
            .din   (wdata[HALF-1:0]),
            .mask  (wdata[DATA_W-1:HALF]),
            .q     (ctrl_q[g])
        );
        assign ctrl_flat[g*HALF +: HALF] = ctrl_q[g];
    end

    phyctl_rd_path #(
        .DATA_W   (DATA_W),
        .NUM_CTRL (NUM_CTRL)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .kind      (kind),
        .sel       (sel),
        .ctrl_flat (ctrl_flat),
        .cal_done  (cal_done_i),
        .dll_ready (dll_ready_i),
        .rdata     (rdata)
    );

    assign pwr_en_o   = ctrl_q[PWR_WORD][PWR_BIT];
    assign dll_en_o   = ctrl_q[PWR_WORD][DLLEN_BIT];
    assign drv_code_o = ctrl_q[PWR_WORD][DRV_LSB +: DRV_W];
    assign dll_freq_o = ctrl_q[DLY_WORD][FREQ_LSB +: FREQ_W];
    assign otap_en_o  = ctrl_q[DLY_WORD][OTEN_BIT];
    assign otap_sel_o = ctrl_q[DLY_WORD][OTSEL_LSB +: OTSEL_W];

endmodule

// File: rtl/phyctl_regbank_chk.sv
module phyctl_regbank_chk
    import phyctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_CTRL    = 7,
    parameter int STATUS_WORD = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [DATA_W-1:0]               wdata,
    input logic [DATA_W-1:0]               rdata,
    input logic                            cal_done_i,
    input logic                            dll_ready_i,
    input logic                            otap_en_o,
    input logic [NUM_CTRL*(DATA_W/2)-1:0]  ctrl_flat
);
    localparam int HALF   = DATA_W / 2;
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_WORD * 4);
    localparam logic [ADDR_W-1:0] DLY_ADDR    = ADDR_W'(DLY_WORD * 4);
    localparam logic [DATA_W-1:0] STAT_MASK   =
        (DATA_W'(1) << CAL_BIT) | (DATA_W'(1) << RDY_BIT);

    logic unmapped_wr;
    assign unmapped_wr = (addr[1:0] != 2'b00) ||
                         (addr[ADDR_W-1:2] >= WIDX_W'(NUM_CTRL));

    // R2: an all-zero enable mask leaves every payload unchanged
    a_r2_zero_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[DATA_W-1:HALF] == '0)) |=> $stable(ctrl_flat));

    // R3: rdata only moves on a read strobe
    a_r3_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R5: tap delay enable keeps its value unless its enable bit is set
    a_r5_otap_en_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == DLY_ADDR) && !wdata[HALF + OTEN_BIT]) |=> $stable(otap_en_o));

    // R6: status read carries the two flags and nothing else
    a_r6_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == STATUS_ADDR)) |=>
            ((rdata[CAL_BIT] == $past(cal_done_i)) &&
             (rdata[RDY_BIT] == $past(dll_ready_i)) &&
             ((rdata & ~STAT_MASK) == '0)));

    // R7: writes outside the control words touch nothing
    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unmapped_wr) |=> $stable(ctrl_flat));

    // R7: reads outside the control and status words return zero
    a_r7_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped_wr && (addr != STATUS_ADDR)) |=> (rdata == '0));

endmodule

bind phyctl_regbank phyctl_regbank_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_CTRL    (NUM_CTRL),
    .STATUS_WORD (STATUS_WORD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .cal_done_i  (cal_done_i),
    .dll_ready_i (dll_ready_i),
    .otap_en_o   (otap_en_o),
    .ctrl_flat   (ctrl_flat)
);

// File: tb/sim_phyctl_regbank.sv
module sim_phyctl_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cal_done_i = 1'b0;
    logic        dll_ready_i = 1'b0;
    logic        pwr_en_o, dll_en_o, otap_en_o;
    logic [2:0]  drv_code_o;
    logic [1:0]  dll_freq_o;
    logic [3:0]  otap_sel_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [15:0] model [7];

    always #(CLK_PERIOD/2) clk = ~clk;

    phyctl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
        .pwr_en_o(pwr_en_o), .dll_en_o(dll_en_o), .drv_code_o(drv_code_o),
        .dll_freq_o(dll_freq_o), .otap_en_o(otap_en_o), .otap_sel_o(otap_sel_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input int w, input logic [31:0] d);
        model[w] = (model[w] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        if (a[1:0] == 2'b00 && a[7:2] < 6'd7) model_wr(int'(a[7:2]), d);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_fields(input string tag);
        chk({tag, " pwr"},  {31'b0, pwr_en_o},   {31'b0, model[6][0]});
        chk({tag, " dll"},  {31'b0, dll_en_o},   {31'b0, model[6][1]});
        chk({tag, " drv"},  {29'b0, drv_code_o}, {29'b0, model[6][6:4]});
        chk({tag, " freq"}, {30'b0, dll_freq_o}, {30'b0, model[0][13:12]});
        chk({tag, " oten"}, {31'b0, otap_en_o},  {31'b0, model[0][11]});
        chk({tag, " osel"}, {28'b0, otap_sel_o}, {28'b0, model[0][10:7]});
    endtask

    task automatic check_all_words(input string tag);
        logic [31:0] v;
        for (int w = 0; w < 7; w++) begin
            do_read(8'(w * 4), v);
            chk(tag, v, {16'h0, model[w]});
        end
    endtask

    task automatic t_reset();
        chk("R1 rdata after reset", rdata, 32'h0);
        check_fields("R1 reset");
        check_all_words("R1 reset word");
    endtask

    task automatic t_masked();
        logic [31:0] v;
        do_write(8'h0C, 32'hFFFF_A5A5);
        do_read(8'h0C, v);
        chk("R2 full-mask write", v, 32'h0000_A5A5);
        do_write(8'h0C, 32'h00F0_0F0F);
        do_read(8'h0C, v);
        chk("R2 partial mask", v, 32'h0000_A505);
        do_write(8'h0C, 32'h0000_FFFF);
        do_read(8'h0C, v);
        chk("R2 zero mask keeps", v, 32'h0000_A505);
    endtask

    task automatic t_plain_words();
        logic [31:0] v;
        for (int w = 1; w <= 5; w++) begin
            do_write(8'(w * 4), {16'hFFFF, 16'(16'h1357 * w + 16'h8000)});
        end
        for (int w = 1; w <= 5; w++) begin
            do_read(8'(w * 4), v);
            chk("R8 word readback", v, {16'h0, 16'(16'h1357 * w + 16'h8000)});
            chk("R3 upper half zero", {16'h0, v[31:16]}, 32'h0);
        end
    endtask

    task automatic t_power_word();
        do_write(8'h18, 32'h0073_0053);
        chk("R4 pwr set", {31'b0, pwr_en_o}, 32'h1);
        chk("R4 dll set", {31'b0, dll_en_o}, 32'h1);
        chk("R4 drive code", {29'b0, drv_code_o}, 32'h5);
        do_write(8'h18, 32'h0002_0000);
        chk("R4 dll cleared alone", {31'b0, dll_en_o}, 32'h0);
        chk("R4 pwr untouched", {31'b0, pwr_en_o}, 32'h1);
        check_fields("R4 fields");
    endtask

    task automatic t_delay_word();
        do_write(8'h00, 32'h3F80_2A00);
        chk("R5 freq code", {30'b0, dll_freq_o}, 32'h2);
        chk("R5 tap enable", {31'b0, otap_en_o}, 32'h1);
        chk("R5 tap select", {28'b0, otap_sel_o}, 32'h4);
        do_write(8'h00, 32'h0780_0780);
        chk("R5 tap select only", {28'b0, otap_sel_o}, 32'hF);
        chk("R5 freq kept", {30'b0, dll_freq_o}, 32'h2);
        check_fields("R5 fields");
    endtask

    task automatic t_status();
        logic [31:0] v;
        cal_done_i = 1'b1; dll_ready_i = 1'b0;
        do_read(8'h20, v);
        chk("R6 cal only", v, 32'h0000_0040);
        cal_done_i = 1'b0; dll_ready_i = 1'b1;
        do_read(8'h20, v);
        chk("R6 ready only", v, 32'h0000_0020);
        cal_done_i = 1'b1;
        do_read(8'h20, v);
        chk("R6 both", v, 32'h0000_0060);
        cal_done_i = 1'b0; dll_ready_i = 1'b0;
        do_read(8'h20, v);
        chk("R6 none", v, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        do_write(8'h20, 32'hFFFF_FFFF);
        do_write(8'h1C, 32'hFFFF_FFFF);
        do_write(8'hFC, 32'hFFFF_FFFF);
        do_write(8'h19, 32'hFFFF_FFFF);
        do_write(8'h02, 32'hFFFF_0000);
        check_fields("R7 after ignored writes");
        check_all_words("R7 word after ignored writes");
        do_read(8'h1C, v);
        chk("R7 read unmapped 0x1C", v, 32'h0);
        do_read(8'hF0, v);
        chk("R7 read unmapped 0xF0", v, 32'h0);
        do_read(8'h0D, v);
        chk("R7 read misaligned", v, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] old_v, v;
        old_v = {16'h0, model[2]};
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h08; wdata = 32'hFFFF_0F0F;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        model_wr(2, 32'hFFFF_0F0F);
        chk("R9 read sees old value", rdata, old_v);
        do_read(8'h08, v);
        chk("R9 next read sees new value", v, 32'h0000_0F0F);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_read(8'h10, v);
        repeat (3) @(negedge clk);
        chk("R3 rdata held while idle", rdata, v);
        do_write(8'h10, 32'hFFFF_0001);
        chk("R3 rdata held across write", rdata, v);
    endtask

    initial begin
        for (int w = 0; w < 7; w++) model[w] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_plain_words();
        t_power_word();
        t_delay_word();
        t_status();
        t_ignored();
        t_collision();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule